// File: doc/BRIEF.md
# Pipelined-Carry Phase Accumulator

This block keeps a running phase value that grows by a programmable increment on every clock cycle. It targets high clock rates: instead of one long carry chain across the full word, the sum is cut into 8-bit slices. Each slice adds its share of the increment and the carry that the slice below produced one cycle earlier. The carry out of every slice is registered before the next slice uses it. Throughput stays at one addition per cycle. The cost is a fixed output latency of one cycle per slice boundary.

The increment is held in a register. An outside control loop, for example a digital PLL that trims the frequency up and down, writes it through a load strobe. The bytes of a new increment follow the same diagonal path through the slices as the carries do, so a change never tears a sum that is already in flight. The lower slices feed skew registers, so every bit of one accumulated value leaves the block on the same cycle. A small fill tracker, written as a state machine, raises the valid flag once the first aligned value reaches the output.

The fill tracker has three states. FILL_EMPTY is entered on reset. On the first enabled cycle it moves to FILL_PRIMING, or to FILL_READY when the latency is one cycle. FILL_PRIMING counts enabled cycles and moves to FILL_READY when the count reaches the latency. FILL_READY is held until reset. Every transition happens only on an enabled cycle. The valid output is high in FILL_READY only.

Top module: `phase_accum_pipe`

## Requirements
- R1: While `step_en_i` is high, the accumulator takes one new addition on every clock cycle, with no stall.
- R2: After the m-th enabled cycle since reset, `phase_o` equals the logical sum S(m-2). Here S(0)=0, S(j)=0 for j<0, and S(j)=S(j-1)+I(j), where I(j) is the increment register value at enabled cycle j. The latency is therefore two enabled cycles for the default three slices.
- R3: The sum wraps modulo 2^24, and no overflow indication exists. For example, 0xFFFFFF plus 0x000002 gives 0x000001.
- R4: When `inc_load_i` is high on a clock edge, `inc_word_i` is written into the increment register, whether or not the step is enabled. The new value is first used at the next enabled cycle. Sums already in flight keep the old value.
- R5: While `step_en_i` is low, `phase_o`, `phase_valid_o` and all pipeline state hold their values.
- R6: A synchronous reset (`rst_i` high at a clock edge) clears the slices, carry registers, skew registers and increment register. After such an edge, `phase_o` is 0 and `phase_valid_o` is 0.
- R7: `phase_valid_o` rises after the second enabled cycle since reset and stays high until the next reset.
- R8: Carries propagate correctly across slice boundaries: bit 7 into bit 8, and bit 15 into bit 16. This includes a ripple through a whole slice of ones.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| step_en_i | input | 1 | Advance accumulator and pipeline |
| inc_load_i | input | 1 | Write strobe for the increment register |
| inc_word_i | input | 24 | New increment value |
| phase_o | output | 24 | Aligned accumulated phase |
| phase_valid_o | output | 1 | Pipeline filled since reset |

## Verification
The accumulator is driven through a sweep of increments, and each one shows a different fault.

- An increment of 1 exposes latency and alignment errors.
- 0xFF and 0xFFFF force carries over each slice boundary.
- 0x010101 exercises every slice at once.
- 0xFFFFFF and 0x800000 drive the sum through the modulo-2^24 wrap.

In further phases the increment is reloaded on every cycle, the enable toggles in an irregular pattern with loads arriving while it is low, and a reset is applied in mid-run. These phases separate a correct diagonal increment path from one that tears in-flight sums, and show whether the freeze and clear behaviour works.

// File: rtl/phase_accum_pkg.sv
package phase_accum_pkg;

    typedef enum logic [1:0] {
        FILL_EMPTY   = 2'd0,
        FILL_PRIMING = 2'd1,
        FILL_READY   = 2'd2
    } fill_state_e;

endpackage

// File: rtl/pa_delay.sv
module pa_delay #(
    parameter int W     = 8,
    parameter int DEPTH = 1
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic         en_i,
    input  logic [W-1:0] din_i,
    output logic [W-1:0] dout_o
);

    generate
        if (DEPTH == 0) begin : g_pass
            assign dout_o = din_i;
        end else begin : g_chain
            logic [DEPTH-1:0][W-1:0] stage_q;

            always_ff @(posedge clk_i) begin
                if (rst_i) begin
                    stage_q <= '0;
                end else if (en_i) begin
                    stage_q[0] <= din_i;
                    for (int i = 1; i < DEPTH; i++) begin
                        stage_q[i] <= stage_q[i-1];
                    end
                end
            end

            assign dout_o = stage_q[DEPTH-1];
        end
    endgenerate

endmodule

// File: rtl/pa_slice.sv
module pa_slice #(
    parameter int SW = 8
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic          en_i,
    input  logic [SW-1:0] addend_i,
    input  logic          cin_i,
    output logic [SW-1:0] acc_o,
    output logic          cout_o
);

    logic [SW-1:0] acc_q;
    logic          cout_q;
    logic [SW:0]   sum_w;

    always_comb begin
        sum_w = {1'b0, acc_q} + {1'b0, addend_i} + {{SW{1'b0}}, cin_i};
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            acc_q  <= '0;
            cout_q <= 1'b0;
        end else if (en_i) begin
            acc_q  <= sum_w[SW-1:0];
            cout_q <= sum_w[SW];
        end
    end

    assign acc_o  = acc_q;
    assign cout_o = cout_q;

endmodule

// File: rtl/pa_fill_fsm.sv
module pa_fill_fsm
    import phase_accum_pkg::*;
#(
    parameter int LAT = 2
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic en_i,
    output logic valid_o
);

    localparam int CW = $clog2(LAT + 1) + 1;

    fill_state_e   state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (en_i) begin
            unique case (state_q)
                FILL_EMPTY: begin
                    cnt_d = CW'(1);
                    if (LAT <= 1) state_d = FILL_READY;
                    else          state_d = FILL_PRIMING;
                end
                FILL_PRIMING: begin
                    cnt_d = cnt_q + CW'(1);
                    if (cnt_d == CW'(LAT)) state_d = FILL_READY;
                end
                FILL_READY: begin
                    state_d = FILL_READY;
                end
                default: begin
                    state_d = FILL_EMPTY;
                    cnt_d   = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q <= FILL_EMPTY;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        unique case (state_q)
            FILL_READY: valid_o = 1'b1;
            default:    valid_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/phase_accum_pipe.sv
module phase_accum_pipe #(
    parameter int W  = 24,
    parameter int SW = 8
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic         step_en_i,
    input  logic         inc_load_i,
    input  logic [W-1:0] inc_word_i,
    output logic [W-1:0] phase_o,
    output logic         phase_valid_o
);

    localparam int NSLICE = W / SW;
    localparam int LAT    = NSLICE - 1;

    logic [W-1:0]              inc_q;
    logic [NSLICE-1:0]         carry_in;
    logic [NSLICE-1:0]         carry_out;
    logic [NSLICE-1:0][SW-1:0] addend;
    logic [NSLICE-1:0][SW-1:0] slice_acc;
    logic [NSLICE-1:0][SW-1:0] slice_aligned;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            inc_q <= '0;
        end else if (inc_load_i) begin
            inc_q <= inc_word_i;
        end
    end

    assign carry_in[0] = 1'b0;

    generate
        for (genvar k = 0; k < NSLICE; k++) begin : g_slice
            if (k > 0) begin : g_link
                assign carry_in[k] = carry_out[k-1];
            end

            pa_delay #(.W(SW), .DEPTH(k)) u_inc_skew (
                .clk_i  (clk_i),
                .rst_i  (rst_i),
                .en_i   (step_en_i),
                .din_i  (inc_q[k*SW +: SW]),
                .dout_o (addend[k])
            );

            pa_slice #(.SW(SW)) u_slice (
                .clk_i    (clk_i),
                .rst_i    (rst_i),
                .en_i     (step_en_i),
                .addend_i (addend[k]),
                .cin_i    (carry_in[k]),
                .acc_o    (slice_acc[k]),
                .cout_o   (carry_out[k])
            );

            pa_delay #(.W(SW), .DEPTH(LAT - k)) u_out_skew (
                .clk_i  (clk_i),
                .rst_i  (rst_i),
                .en_i   (step_en_i),
                .din_i  (slice_acc[k]),
                .dout_o (slice_aligned[k])
            );

            assign phase_o[k*SW +: SW] = slice_aligned[k];
        end
    endgenerate

    pa_fill_fsm #(.LAT(LAT)) u_fill (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .en_i    (step_en_i),
        .valid_o (phase_valid_o)
    );

endmodule

// File: rtl/pa_checker.sv
module pa_checker #(
    parameter int W  = 24,
    parameter int SW = 8
) (
    input logic         clk_i,
    input logic         rst_i,
    input logic         step_en_i,
    input logic         inc_load_i,
    input logic [W-1:0] inc_word_i,
    input logic [W-1:0] phase_o,
    input logic         phase_valid_o
);

    localparam int LAT = (W / SW) - 1;

    logic [W-1:0] shadow_q;
    logic [W-1:0] used_q [LAT];

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            shadow_q <= '0;
            for (int i = 0; i < LAT; i++) used_q[i] <= '0;
        end else begin
            if (inc_load_i) shadow_q <= inc_word_i;
            if (step_en_i) begin
                used_q[0] <= shadow_q;
                for (int i = 1; i < LAT; i++) used_q[i] <= used_q[i-1];
            end
        end
    end

    AST_STEP_DELTA: assert property (@(posedge clk_i) disable iff (rst_i)
        (step_en_i && phase_valid_o) |=> (phase_o == W'($past(phase_o) + $past(used_q[LAT-1])))); // R2

    AST_FREEZE: assert property (@(posedge clk_i) disable iff (rst_i)
        !step_en_i |=> ($stable(phase_o) && $stable(phase_valid_o))); // R5

    AST_VALID_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
        phase_valid_o |=> phase_valid_o); // R7

    AST_RESET_CLEAR: assert property (@(posedge clk_i)
        rst_i |=> (phase_o == '0 && !phase_valid_o)); // R6

endmodule

bind phase_accum_pipe pa_checker #(.W(W), .SW(SW)) u_pa_checker (
    .clk_i         (clk_i),
    .rst_i         (rst_i),
    .step_en_i     (step_en_i),
    .inc_load_i    (inc_load_i),
    .inc_word_i    (inc_word_i),
    .phase_o       (phase_o),
    .phase_valid_o (phase_valid_o)
);

// File: tb/phase_accum_pipe_bench.sv
module phase_accum_pipe_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic        en;
    logic        ld;
    logic [23:0] inc;
    logic [23:0] phase;
    logic        valid;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    // bench model of the logical sum history
    logic [23:0] m_inc, s0, s1, s2;
    int          m_steps;

    always #4 clk = ~clk;

    phase_accum_pipe u_phase_accum_pipe (
        .clk_i         (clk),
        .rst_i         (rst),
        .step_en_i     (en),
        .inc_load_i    (ld),
        .inc_word_i    (inc),
        .phase_o       (phase),
        .phase_valid_o (valid)
    );

    task automatic model_reset();
        m_inc = '0; s0 = '0; s1 = '0; s2 = '0; m_steps = 0;
    endtask

    task automatic compare(input string tag);
        logic exp_v;
        exp_v = (m_steps >= 2);
        checks++;
        if (phase !== s2 || valid !== exp_v) begin
            errors++;
            $display("FAIL %s phase got %h exp %h valid got %b exp %b",
                     tag, phase, s2, valid, exp_v);
        end
    endtask

    // drive one cycle after a negedge, update model at the edge, check at next negedge
    task automatic tick(input logic e, input logic l, input logic [23:0] v, input string tag);
        en = e; ld = l; inc = v;
        @(posedge clk);
        if (e) begin
            s2 = s1; s1 = s0; s0 = s0 + m_inc;
            m_steps++;
        end
        if (l) m_inc = v;
        @(negedge clk);
        compare(tag);
    endtask

    task automatic do_reset(input string tag);
        rst = 1'b1; en = 1'b0; ld = 1'b0; inc = '0;
        @(posedge clk);
        model_reset();
        @(negedge clk);
        compare(tag);
        rst = 1'b0;
    endtask

    initial begin
        logic [23:0] sweep [8];
        sweep[0] = 24'h000001; sweep[1] = 24'h0000FF; sweep[2] = 24'h00FFFF;
        sweep[3] = 24'h010101; sweep[4] = 24'hFFFFFF; sweep[5] = 24'h800000;
        sweep[6] = 24'h123457; sweep[7] = 24'h7FFF81;
        rst = 1'b1; en = 1'b0; ld = 1'b0; inc = '0;
        model_reset();
        repeat (2) @(negedge clk);
        do_reset("R6 reset state");

        // fill and latency with increment 1
        tick(1'b0, 1'b1, 24'h000001, "R4 load while idle");
        for (int i = 0; i < 8; i++) tick(1'b1, 1'b0, '0, "R7 R2 fill latency");

        // sweep over increments covering slice carries and wrap
        for (int k = 0; k < 8; k++) begin
            tick(1'b1, 1'b1, sweep[k], "R4 load in stream");
            for (int i = 0; i < 300; i++)
                tick(1'b1, 1'b0, '0, (k == 1 || k == 2) ? "R8 slice carry" :
                                     (k == 4 || k == 5) ? "R3 wrap" : "R1 every cycle");
        end

        // ripple through full slice of ones: start near 0x00FFFF boundary
        do_reset("R6 reset mid run");
        tick(1'b1, 1'b1, 24'h00FFFF, "R8 ripple load");
        for (int i = 0; i < 6; i++) tick(1'b1, 1'b0, '0, "R8 ripple");
        tick(1'b1, 1'b1, 24'h000001, "R8 ripple reload");
        for (int i = 0; i < 6; i++) tick(1'b1, 1'b0, '0, "R8 ripple 16");

        // increment changed on every cycle
        for (int i = 0; i < 400; i++)
            tick(1'b1, 1'b1, 24'((i * 24'h03A7F1) ^ (i << 9)), "R4 reload every cycle");

        // enable toggling with loads while frozen
        for (int i = 0; i < 500; i++)
            tick((i % 3) != 1 && (i % 7) != 0, (i % 5) == 0, 24'((i * 24'h0F1E2D) + 24'h00FF80),
                 "R5 enable gaps");

        // reset during operation, then refill
        do_reset("R6 reset clears");
        for (int i = 0; i < 4; i++) tick(1'b0, 1'b0, '0, "R5 idle after reset");
        tick(1'b1, 1'b1, 24'hFFFFFE, "R7 refill");
        for (int i = 0; i < 20; i++) tick(1'b1, 1'b0, '0, "R3 R7 refill wrap");

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule